// File: doc/BRIEF.md
# Sequencer host register interface

This block is the host-facing register bank of a pattern sequencer. A simple word-addressed bus with separate read and write strobes reaches a small set of 32-bit registers. Program words for the sequencer are 128 bits wide. The host loads them a quarter at a time into staging registers, and the write of the top quarter commits the assembled word to the program memory. The word goes to the location held in the program address register.

The bank also holds the sequencer controls: a run request and four mode bits. Reads of the control word return live status from the core. The bank keeps a scratch register for bus checks and a per-output inversion mask, and it returns fixed identification words. It forms the final output pattern: the sequencer pattern is normally passed through, and in test mode the address register is routed out instead. The inversion mask is applied last, and the result goes out through a register.

Top module: `seq_host_regs`

## Requirements
- R1: After synchronous reset, every writable register reads 0, and `host_rdata`, `out_pattern`, `pm_we`, `run_req` and all mode outputs are 0.
- R2: The scratch register at word index 1 (byte offset 0x04) returns the last value written to it.
- R3: The address register at index 2 (0x08) reads back its full 32-bit value. Its low `PMEM_AW` bits drive `start_addr`.
- R4: The instruction parts at indices 3, 4, 5 and 6 (0x0C..0x18) hold bits 31:0, 63:32, 95:64 and 127:96 respectively. Writing indices 3 to 5 never raises `pm_we`. A write to index 6 raises `pm_we` for exactly one cycle, in the cycle after the write. In that cycle `pm_wdata` is {written word, part 5, part 4, part 3} and `pm_waddr` is the address register's low bits.
- R5: All four instruction parts read back their last written values.
- R6: A control write (index 0) with bit 0 = 1 and bit 2 = 0 produces a one-cycle `run_req` pulse in the following cycle. When bit 2 (external start enable) is 1 in the written word, no pulse is produced.
- R7: The control word bits are mapped as follows. Bit 1 drives `ext_clk_sel`, bit 2 drives `ext_start_en`, bit 3 drives `slow_clk_sel` and bit 4 drives `test_mode`; these bits are writable and read back. On read, bit 0 returns `core_running` and bits 31:5 return `core_status`. Writes to bits 31:5 and to the stored state of bit 0 have no effect.
- R8: Outside test mode, `out_pattern` equals `pattern_in` XOR the inversion mask (index 7, 0x1C), one cycle after its inputs.
- R9: In test mode, `out_pattern` equals the address register XOR the inversion mask, one cycle after its inputs.
- R10: The following read-only words are fixed. Index 8 (0x20) returns `VERSION_ID`, index 10 (0x28) returns `SERIAL_ID` and index 11 (0x2C) returns `HW_ID`; writes to these words are ignored. Index 9 and indices 12 to 15 read 0.
- R11: `host_rdata` is loaded on the clock edge where `host_rd` is high and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | REG_AW | Register word index |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Registered read data |
| pm_we | output | 1 | Program memory write enable |
| pm_waddr | output | PMEM_AW | Program memory write address |
| pm_wdata | output | 4*DATA_W | Program memory write word |
| start_addr | output | PMEM_AW | Execution start address |
| run_req | output | 1 | One-cycle start request |
| ext_clk_sel | output | 1 | External clock select |
| ext_start_en | output | 1 | External start enable |
| slow_clk_sel | output | 1 | Slow clock select |
| test_mode | output | 1 | Test mode |
| core_running | input | 1 | Sequencer running flag |
| core_status | input | DATA_W-5 | Live counter/pointer status |
| pattern_in | input | DATA_W | Sequencer output pattern |
| out_pattern | output | DATA_W | Final registered output |

## Verification
The bench sweeps every word index with distinct values and then reads all of them back. A decoder that aliases two indices would return the wrong word, and a register that failed to ignore writes would return the written value in place of its constant or its live status. Committing on a write to a lower instruction part, or concatenating the parts in the wrong order, would show up as a stray or scrambled `pm_wdata`. The bench also walks a single set bit through the inversion mask, so a mask bit on the wrong output lane is caught. It then checks that test mode routes the address register through the mask, that external start suppresses the run pulse, and that the read data holds between reads.

// File: rtl/seq_host_pkg.sv
package seq_host_pkg;
  localparam int IDX_CTRL    = 0;
  localparam int IDX_SCRATCH = 1;
  localparam int IDX_ADDR    = 2;
  localparam int IDX_PART0   = 3;
  localparam int IDX_PART3   = 6;
  localparam int IDX_MASK    = 7;
  localparam int IDX_VERSION = 8;
  localparam int IDX_SERIAL  = 10;
  localparam int IDX_HWID    = 11;
  localparam int NUM_IDX     = 12;
  localparam int NUM_PARTS   = 4;
  localparam int MODE_BITS   = 4;
endpackage

// File: rtl/seq_host_decode.sv
module seq_host_decode #(
  parameter int REG_AW = 4,
  parameter int NSEL   = 12
) (
  input  logic [REG_AW-1:0] addr,
  output logic [NSEL-1:0]   sel
);
  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    assign sel[i] = (addr == REG_AW'(i));
  end
endmodule

// File: rtl/seq_host_stage.sv
module seq_host_stage #(
  parameter int W       = 32,
  parameter int PARTS   = 4,
  parameter int PMEM_AW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [PARTS-1:0]     sel_part,
  input  logic [W-1:0]         wdata,
  input  logic [PMEM_AW-1:0]   waddr,
  output logic [PARTS*W-1:0]   part_q,
  output logic                 pm_we,
  output logic [PMEM_AW-1:0]   pm_waddr,
  output logic [PARTS*W-1:0]   pm_wdata
);
  localparam int TOP = PARTS - 1;

  for (genvar p = 0; p < PARTS; p++) begin : g_part
    always_ff @(posedge clk) begin
      if (rst)                    part_q[p*W +: W] <= '0;
      else if (wr && sel_part[p]) part_q[p*W +: W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_we    <= 1'b0;
      pm_waddr <= '0;
      pm_wdata <= '0;
    end else begin
      pm_we <= wr && sel_part[TOP];
      if (wr && sel_part[TOP]) begin
        pm_waddr                 <= waddr;
        pm_wdata[TOP*W +: W]     <= wdata;
        pm_wdata[TOP*W-1:0]      <= part_q[TOP*W-1:0];
      end
    end
  end

  p_commit_top_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && sel_part[TOP]) |=> (pm_we && pm_wdata[TOP*W +: W] == $past(wdata)
                               && pm_waddr == $past(waddr)));
  p_no_commit_low_r4: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel_part[TOP]) |=> !pm_we);
endmodule

// File: rtl/seq_host_outmux.sv
module seq_host_outmux #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_mode,
  input  logic [W-1:0] addr_val,
  input  logic [W-1:0] pattern,
  input  logic [W-1:0] inv_mask,
  output logic [W-1:0] out_q
);
  logic [W-1:0] chosen;
  always_comb chosen = test_mode ? addr_val : pattern;

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= chosen ^ inv_mask;
  end

  p_test_route_r9: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> (out_q == ($past(addr_val) ^ $past(inv_mask))));
  p_normal_route_r8: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> (out_q == ($past(pattern) ^ $past(inv_mask))));
endmodule

// File: rtl/seq_host_regs.sv
module seq_host_regs
  import seq_host_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          REG_AW     = 4,
  parameter int          PMEM_AW    = 12,
  parameter logic [31:0] VERSION_ID = 32'h5EC0_0107,
  parameter logic [31:0] SERIAL_ID  = 32'h0000_0A21,
  parameter logic [31:0] HW_ID      = 32'h9A77_3200
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [REG_AW-1:0]        host_addr,
  input  logic [DATA_W-1:0]        host_wdata,
  output logic [DATA_W-1:0]        host_rdata,
  output logic                     pm_we,
  output logic [PMEM_AW-1:0]       pm_waddr,
  output logic [4*DATA_W-1:0]      pm_wdata,
  output logic [PMEM_AW-1:0]       start_addr,
  output logic                     run_req,
  output logic                     ext_clk_sel,
  output logic                     ext_start_en,
  output logic                     slow_clk_sel,
  output logic                     test_mode,
  input  logic                     core_running,
  input  logic [DATA_W-6:0]        core_status,
  input  logic [DATA_W-1:0]        pattern_in,
  output logic [DATA_W-1:0]        out_pattern
);
  localparam int STAT_W = DATA_W - 5;
  localparam int NSEL   = 1 << REG_AW;

  logic [NSEL-1:0]             sel;
  logic [DATA_W-1:0]           scratch_q, addr_q, mask_q;
  logic [MODE_BITS-1:0]        mode_q;
  logic [NUM_PARTS*DATA_W-1:0] part_q;
  logic [DATA_W-1:0]           rd_mux;

  seq_host_decode #(.REG_AW(REG_AW), .NSEL(NSEL)) u_dec (
    .addr(host_addr), .sel(sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch_q <= '0;
      addr_q    <= '0;
      mask_q    <= '0;
      mode_q    <= '0;
      run_req   <= 1'b0;
    end else begin
      run_req <= 1'b0;
      if (host_wr) begin
        if (sel[IDX_SCRATCH]) scratch_q <= host_wdata;
        if (sel[IDX_ADDR])    addr_q    <= host_wdata;
        if (sel[IDX_MASK])    mask_q    <= host_wdata;
        if (sel[IDX_CTRL]) begin
          mode_q  <= host_wdata[MODE_BITS:1];
          run_req <= host_wdata[0] & ~host_wdata[2];
        end
      end
    end
  end

  assign ext_clk_sel  = mode_q[0];
  assign ext_start_en = mode_q[1];
  assign slow_clk_sel = mode_q[2];
  assign test_mode    = mode_q[3];
  assign start_addr   = addr_q[PMEM_AW-1:0];

  seq_host_stage #(.W(DATA_W), .PARTS(NUM_PARTS), .PMEM_AW(PMEM_AW)) u_stage (
    .clk(clk), .rst(rst), .wr(host_wr),
    .sel_part(sel[IDX_PART3:IDX_PART0]),
    .wdata(host_wdata), .waddr(addr_q[PMEM_AW-1:0]),
    .part_q(part_q), .pm_we(pm_we), .pm_waddr(pm_waddr), .pm_wdata(pm_wdata)
  );

  seq_host_outmux #(.W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .test_mode(test_mode), .addr_val(addr_q),
    .pattern(pattern_in), .inv_mask(mask_q), .out_q(out_pattern)
  );

  always_comb begin
    rd_mux = '0;
    case (int'(host_addr))
      IDX_CTRL:    rd_mux = {core_status, mode_q, core_running};
      IDX_SCRATCH: rd_mux = scratch_q;
      IDX_ADDR:    rd_mux = addr_q;
      IDX_MASK:    rd_mux = mask_q;
      IDX_VERSION: rd_mux = VERSION_ID[DATA_W-1:0];
      IDX_SERIAL:  rd_mux = SERIAL_ID[DATA_W-1:0];
      IDX_HWID:    rd_mux = HW_ID[DATA_W-1:0];
      default: begin
        for (int p = 0; p < NUM_PARTS; p++)
          if (int'(host_addr) == IDX_PART0 + p) rd_mux = part_q[p*DATA_W +: DATA_W];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

  p_run_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    (host_wr && sel[IDX_CTRL] && host_wdata[2]) |=> !run_req);
  p_status_live_r7: assert property (@(posedge clk) disable iff (rst)
    (host_rd && sel[IDX_CTRL]) |=> (host_rdata[DATA_W-1:5] == $past(core_status)
                                    && host_rdata[0] == $past(core_running)));
  p_scratch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && sel[IDX_SCRATCH]) |=> $stable(scratch_q));
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
  p_version_fixed_r10: assert property (@(posedge clk) disable iff (rst)
    (host_rd && sel[IDX_VERSION]) |=> host_rdata == VERSION_ID[DATA_W-1:0]);
  p_stat_width_r7: assert property (@(posedge clk) disable iff (rst)
    run_req |-> $past(host_wr));

  initial begin
    a_stat_w_r7: assert (STAT_W + MODE_BITS + 1 == DATA_W);
  end
endmodule

// File: tb/tb_seq_host_regs.sv
module tb_seq_host_regs;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int PA = 12;
  localparam logic [31:0] VER = 32'h5EC0_0107;
  localparam logic [31:0] SER = 32'h0000_0A21;
  localparam logic [31:0] HWI = 32'h9A77_3200;

  logic clk = 0, rst = 1;
  logic host_wr = 0, host_rd = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata;
  logic pm_we;
  logic [PA-1:0] pm_waddr, start_addr;
  logic [4*DW-1:0] pm_wdata;
  logic run_req, ext_clk_sel, ext_start_en, slow_clk_sel, test_mode;
  logic core_running = 0;
  logic [DW-6:0] core_status = '0;
  logic [DW-1:0] pattern_in = '0, out_pattern;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [DW-1:0] model [16];
  logic [DW-1:0] rv;

  always #5 clk = ~clk;

  seq_host_regs dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pm_we(pm_we), .pm_waddr(pm_waddr), .pm_wdata(pm_wdata),
    .start_addr(start_addr), .run_req(run_req), .ext_clk_sel(ext_clk_sel),
    .ext_start_en(ext_start_en), .slow_clk_sel(slow_clk_sel),
    .test_mode(test_mode), .core_running(core_running),
    .core_status(core_status), .pattern_in(pattern_in), .out_pattern(out_pattern)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = AW'(idx); host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input int idx, output logic [DW-1:0] d);
    @(negedge clk);
    host_rd = 1; host_addr = AW'(idx);
    @(negedge clk);
    host_rd = 0;
    d = host_rdata;
  endtask

  function automatic logic [DW-1:0] expect_rd(input int idx);
    case (idx)
      0: return {core_status, test_mode, slow_clk_sel, ext_start_en, ext_clk_sel, core_running};
      1, 2, 3, 4, 5, 6, 7: return model[idx];
      8: return VER;
      10: return SER;
      11: return HWI;
      default: return '0;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 rdata", host_rdata, 0);
    chk("R1 out", out_pattern, 0);
    chk("R1 pm_we/run", {pm_we, run_req}, 0);
    chk("R1 modes", {ext_clk_sel, ext_start_en, slow_clk_sel, test_mode}, 0);
    for (int i = 1; i < 8; i++) begin
      rd(i, rv);
      chk("R1 reg zero", rv, 0);
    end

    // Sweep: distinct writes to every index
    core_status = 27'h5A5_1C3;
    for (int i = 0; i < 16; i++) begin
      logic [DW-1:0] v;
      v = 32'h9E00_0000 ^ (32'(i) * 32'h0101_0111);
      if (i == 0) v = 32'hFFFF_FFE0 | 32'h0A; // R7: status bits written, ext clk + slow set
      wr(i, v);
      if (i >= 1 && i <= 7) model[i] = v;
      if (i >= 3 && i <= 5) chk("R4 no commit on low part", pm_we, 0);
      if (i == 6) begin
        chk("R4 commit pulse", pm_we, 1);
        chk("R4 commit data", pm_wdata, {v, model[5], model[4], model[3]});
        chk("R4 commit addr", pm_waddr, model[2][PA-1:0]);
        @(negedge clk);
        chk("R4 single pulse", pm_we, 0);
      end
      if (i == 0) chk("R6 no run without bit0", run_req, 0);
    end
    chk("R7 mode ports", {test_mode, slow_clk_sel, ext_start_en, ext_clk_sel}, 4'b0101);
    chk("R3 start_addr", start_addr, model[2][PA-1:0]);
    for (int i = 0; i < 16; i++) begin
      rd(i, rv);
      if (i == 1) chk("R2 scratch", rv, expect_rd(i));
      else if (i == 2) chk("R3 addr", rv, expect_rd(i));
      else if (i >= 3 && i <= 6) chk("R5 part", rv, expect_rd(i));
      else if (i == 0) chk("R7 ctrl read", rv, expect_rd(i));
      else chk("R10 const/unmapped", rv, expect_rd(i));
    end

    // R7: live running bit and status
    core_running = 1; core_status = 27'h000_0F1;
    rd(0, rv);
    chk("R7 running/status", rv, expect_rd(0));
    core_running = 0;

    // R11: rdata holds without read strobe
    rd(2, rv);
    @(negedge clk); host_addr = 4'd8;
    @(negedge clk); @(negedge clk);
    chk("R11 hold", host_rdata, model[2]);

    // R6: run pulse and blocking
    wr(0, 32'h1);
    chk("R6 run pulse", run_req, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", run_req, 0);
    wr(0, 32'h5);
    chk("R6 blocked by ext start", run_req, 0);
    chk("R7 ext start port", ext_start_en, 1);
    @(negedge clk);
    chk("R6 still blocked", run_req, 0);
    wr(0, 32'h0);

    // R8: walking inversion bit
    pattern_in = 32'h0F0F_3C3C;
    for (int b = 0; b < DW; b++) begin
      wr(7, 32'h1 << b);
      @(negedge clk);
      chk("R8 mask walk", out_pattern, pattern_in ^ (32'h1 << b));
    end
    wr(7, 32'h0);
    pattern_in = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("R8 plain pass", out_pattern, 32'hDEAD_BEEF);

    // R9: test mode routes address through mask
    wr(7, 32'h0000_FFFF);
    wr(0, 32'h10);
    chk("R9 test port", test_mode, 1);
    for (int k = 0; k < 6; k++) begin
      logic [DW-1:0] a;
      a = 32'h1234_5678 * 32'(k + 1);
      wr(2, a);
      @(negedge clk);
      chk("R9 test out", out_pattern, a ^ 32'h0000_FFFF);
    end
    wr(0, 32'h0);
    @(negedge clk);
    chk("R8 back to pattern", out_pattern, 32'hDEAD_BEEF ^ 32'h0000_FFFF);

    finish_run();
  end
endmodule